// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns an addressing-mode code and its operands into the final memory address of a load or store. A one-cycle start pulse hands it a mode, a data size, a base register number, an index register number and a 16-bit constant. The unit reads register contents through a single combinational register-file read port. It fetches pointers through a data-memory read port whose data returns one cycle after the request. When the address is ready it raises a one-cycle done pulse.

The simple modes finish in one cycle. A mode that needs a second register spends one extra cycle on the shared read port. A mode that takes its pointer from memory spends two more cycles on one memory read. The auto-increment and auto-decrement modes also return the modified pointer as a register writeback. Their pre variants give the modified pointer as the address, and their post variants give the original pointer. All address arithmetic wraps modulo 2^16.

Top module: `ea_gen`

## Requirements
- R1: While reset is held, and in the cycles after it until the first start, done_o, mem_req_o and wb_en_o are all low.
- R2: Mode codes 0 (immediate) and 1 (register), and the unused codes 12 to 15, raise done_o in the first cycle after the start edge. They do so with addr_valid_o low, no memory request and no writeback.
- R3: Mode 2 (direct) gives disp_i as the address, and mode 3 (register indirect) gives the contents of register base_i. Both finish in the first cycle after start, with addr_valid_o high.
- R4: Modes 4 (pre-increment) and 6 (pre-decrement) give the base register plus or minus the step as the address. They also write that same value back to register base_i.
- R5: Modes 5 (post-increment) and 7 (post-decrement) give the unmodified base register as the address. They write back the base register plus or minus the step.
- R6: The step is chosen by size_i: 00 selects 1, 01 selects 2, and 10 or 11 selects 4. Every sum and difference wraps modulo 2^16.
- R7: Mode 8 (displacement) gives disp_i plus the base register and finishes in the first cycle after start.
- R8: Mode 9 (indexed) gives the base register plus the index register, reads the index in a second cycle, and raises done_o two cycles after start.
- R9: Mode 10 (memory indirect) issues exactly one memory read at the base register contents. The word returned becomes the address, with done_o three cycles after start.
- R10: Mode 11 (scaled-index indirect) issues exactly one memory read at disp_i + base + 4 × index. The word returned becomes the address, with done_o four cycles after start.
- R11: done_o is a single-cycle pulse, and a start that arrives while an operation is in flight is ignored.
- R12: wb_en_o is raised only in modes 4 to 7. It is raised only in the done cycle, at most once per operation, and wb_idx_o equals base_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| mode_i | input | 4 | Addressing-mode code |
| size_i | input | 2 | Data size code for the step |
| base_i | input | 4 | Base (pointer) register number |
| idx_i | input | 4 | Index register number |
| disp_i | input | 16 | Constant operand |
| rf_raddr_o | output | 4 | Register-file read address |
| rf_rdata_i | input | 16 | Register-file read data, same cycle |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 16 | Memory read data, one cycle after request |
| done_o | output | 1 | Result valid this cycle |
| addr_valid_o | output | 1 | The mode produced a memory address |
| addr_o | output | 16 | Final effective address |
| wb_en_o | output | 1 | Pointer writeback strobe |
| wb_idx_o | output | 4 | Writeback register number |
| wb_data_o | output | 16 | Writeback value |

## Verification
The assertions assume that the register file answers rf_raddr_o in the same cycle. They also assume that memory data is valid exactly in the cycle after mem_req_o, and that mode, size, register numbers and constant matter only in the start cycle. The bench models a combinational register array and a registered memory whose read value is a fixed function of the address. It changes operands only at the falling edge of a start cycle, so each result is predictable from the inputs alone. Starts sent while busy are deliberately fed to the unit. This shows they are dropped, and the in-flight operation still keeps its latency and its single done pulse.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [3:0] {
    M_IMM     = 4'd0,
    M_REG     = 4'd1,
    M_DIR     = 4'd2,
    M_RIND    = 4'd3,
    M_PREINC  = 4'd4,
    M_POSTINC = 4'd5,
    M_PREDEC  = 4'd6,
    M_POSTDEC = 4'd7,
    M_DISP    = 4'd8,
    M_IDX     = 4'd9,
    M_MIND    = 4'd10,
    M_SCIND   = 4'd11
  } ea_mode_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_IDX   = 3'd1,
    S_MREQ  = 3'd2,
    S_MWAIT = 3'd3,
    S_FIN   = 3'd4
  } ea_state_e;

  function automatic logic mode_auto(input logic [3:0] m);
    return (m == M_PREINC) || (m == M_POSTINC) || (m == M_PREDEC) || (m == M_POSTDEC);
  endfunction

  function automatic logic mode_index(input logic [3:0] m);
    return (m == M_IDX) || (m == M_SCIND);
  endfunction

  function automatic logic mode_mem(input logic [3:0] m);
    return (m == M_MIND) || (m == M_SCIND);
  endfunction

  function automatic logic mode_addr(input logic [3:0] m);
    return (m >= M_DIR) && (m <= M_SCIND);
  endfunction

endpackage

// File: rtl/ea_rst_sync.sv
module ea_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/ea_first.sv
module ea_first
  import ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [3:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] reg_i,
  input  logic [AW-1:0] disp_i,
  output logic [AW-1:0] acc_o,
  output logic [AW-1:0] wb_o
);
  logic [AW-1:0] step;
  logic [AW-1:0] inc;
  logic [AW-1:0] dec;

  always_comb begin
    case (size_i)
      2'b00:   step = AW'(1);
      2'b01:   step = AW'(2);
      default: step = AW'(4);
    endcase
  end

  assign inc = reg_i + step;
  assign dec = reg_i - step;

  always_comb begin
    case (mode_i)
      M_DIR:                             acc_o = disp_i;
      M_RIND, M_POSTINC, M_POSTDEC,
      M_MIND, M_IDX:                     acc_o = reg_i;
      M_PREINC:                          acc_o = inc;
      M_PREDEC:                          acc_o = dec;
      M_DISP, M_SCIND:                   acc_o = disp_i + reg_i;
      default:                           acc_o = '0;
    endcase
    wb_o = ((mode_i == M_PREINC) || (mode_i == M_POSTINC)) ? inc : dec;
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [RW-1:0] base_i,
  input  logic [RW-1:0] idx_i,
  input  logic [AW-1:0] first_acc_i,
  input  logic [AW-1:0] first_wb_i,
  output logic [RW-1:0] rf_raddr_o,
  input  logic [AW-1:0] rf_rdata_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          addr_valid_o,
  output logic [AW-1:0] addr_o,
  output logic          wb_en_o,
  output logic [RW-1:0] wb_idx_o,
  output logic [AW-1:0] wb_data_o
);
  localparam int SHIFT = 2;

  ea_state_e     state_q, state_d;
  logic [3:0]    mode_q;
  logic [RW-1:0] base_q, idx_q;
  logic [AW-1:0] acc_q, acc_d, wb_q;
  logic          cap_en, acc_en;
  logic [AW-1:0] idx_term;

  assign cap_en   = (state_q == S_IDLE) && start_i;
  assign acc_en   = cap_en || (state_q == S_IDX) || (state_q == S_MWAIT);
  assign idx_term = (mode_q == M_SCIND) ? (rf_rdata_i << SHIFT) : rf_rdata_i;

  always_comb begin
    state_d = state_q;
    acc_d   = acc_q;
    case (state_q)
      S_IDLE: begin
        acc_d = first_acc_i;
        if (start_i) begin
          if (mode_index(mode_i))    state_d = S_IDX;
          else if (mode_mem(mode_i)) state_d = S_MREQ;
          else                       state_d = S_FIN;
        end
      end
      S_IDX: begin
        acc_d   = acc_q + idx_term;
        state_d = mode_mem(mode_q) ? S_MREQ : S_FIN;
      end
      S_MREQ:  state_d = S_MWAIT;
      S_MWAIT: begin
        acc_d   = mem_rdata_i;
        state_d = S_FIN;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      acc_q   <= '0;
      wb_q    <= '0;
    end else begin
      state_q <= state_d;
      if (cap_en) begin
        mode_q <= mode_i;
        base_q <= base_i;
        idx_q  <= idx_i;
        wb_q   <= first_wb_i;
      end
      if (acc_en) acc_q <= acc_d;
    end
  end

  always_comb begin
    case (state_q)
      S_IDLE:  rf_raddr_o = base_i;
      S_IDX:   rf_raddr_o = idx_q;
      default: rf_raddr_o = base_q;
    endcase
  end

  assign mem_req_o    = (state_q == S_MREQ);
  assign mem_addr_o   = acc_q;
  assign done_o       = (state_q == S_FIN);
  assign addr_o       = acc_q;
  assign addr_valid_o = done_o && mode_addr(mode_q);
  assign wb_en_o      = done_o && mode_auto(mode_q);
  assign wb_idx_o     = base_q;
  assign wb_data_o    = wb_q;

  // R11: done is a pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R11: operation fields hold while busy, so a late start is ignored
  a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> $stable(mode_q) && $stable(base_q));
  // R12: writeback only alongside done
  a_r12_wb_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> done_o);
  // R2: simple modes finish on the next cycle
  a_r2_simple_next: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && start_i && !mode_index(mode_i) && !mode_mem(mode_i)) |=> done_o);
  // R9: memory read only in pointer-fetch modes, result two cycles later
  a_r9_mem_mode: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> mode_mem(mode_q));
  a_r9_mem_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o ##1 done_o);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [1:0]    size_i,
  input  logic [RW-1:0] base_i,
  input  logic [RW-1:0] idx_i,
  input  logic [AW-1:0] disp_i,
  output logic [RW-1:0] rf_raddr_o,
  input  logic [AW-1:0] rf_rdata_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          addr_valid_o,
  output logic [AW-1:0] addr_o,
  output logic          wb_en_o,
  output logic [RW-1:0] wb_idx_o,
  output logic [AW-1:0] wb_data_o
);
  logic          rst_n;
  logic [AW-1:0] first_acc, first_wb;

  ea_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  ea_first #(.AW(AW)) u_first (
    .mode_i (mode_i),
    .size_i (size_i),
    .reg_i  (rf_rdata_i),
    .disp_i (disp_i),
    .acc_o  (first_acc),
    .wb_o   (first_wb)
  );

  ea_ctrl #(.AW(AW), .RW(RW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mode_i       (mode_i),
    .base_i       (base_i),
    .idx_i        (idx_i),
    .first_acc_i  (first_acc),
    .first_wb_i   (first_wb),
    .rf_raddr_o   (rf_raddr_o),
    .rf_rdata_i   (rf_rdata_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rdata_i  (mem_rdata_i),
    .done_o       (done_o),
    .addr_valid_o (addr_valid_o),
    .addr_o       (addr_o),
    .wb_en_o      (wb_en_o),
    .wb_idx_o     (wb_idx_o),
    .wb_data_o    (wb_data_o)
  );

  // R1: quiet while reset is asserted
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !done_o && !mem_req_o && !wb_en_o);
endmodule

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  size = '0;
  logic [3:0]  base = '0;
  logic [3:0]  idx = '0;
  logic [15:0] disp = '0;
  logic [3:0]  rf_raddr;
  logic [15:0] rf_rdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        done, addr_valid, wb_en;
  logic [15:0] addr, wb_data;
  logic [3:0]  wb_idx;

  logic [15:0] regs [16];
  int total = 0;
  int fails = 0;
  bit mon_on = 1'b0;
  int mreq_n = 0;
  int wb_n = 0;
  int done_n = 0;
  logic [15:0] mreq_a = '0;

  always #2 clk = ~clk;

  ea_gen u_ea_gen (
    .clk(clk), .arst_n(arst_n), .start_i(start), .mode_i(mode), .size_i(size),
    .base_i(base), .idx_i(idx), .disp_i(disp), .rf_raddr_o(rf_raddr),
    .rf_rdata_i(rf_rdata), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .done_o(done), .addr_valid_o(addr_valid),
    .addr_o(addr), .wb_en_o(wb_en), .wb_idx_o(wb_idx), .wb_data_o(wb_data)
  );

  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A5A;
  endfunction

  assign rf_rdata = regs[rf_raddr];

  always @(posedge clk) begin
    if (mem_req) mem_rdata <= memf(mem_addr);
    if (mon_on) begin
      if (mem_req) begin mreq_n++; mreq_a = mem_addr; end
      if (wb_en) wb_n++;
      if (done) done_n++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input string tag, input int m, input int sz, input int b, input int ix,
                        input logic [15:0] d, input bit ev, input logic [15:0] ea, input int el,
                        input bit ewb, input logic [15:0] ewd, input int emr, input logic [15:0] ema);
    int lat;
    @(negedge clk);
    mode = 4'(m); size = 2'(sz); base = 4'(b); idx = 4'(ix); disp = d; start = 1'b1;
    mreq_n = 0; wb_n = 0; done_n = 0; mon_on = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 12) begin @(negedge clk); lat++; end
    chk({tag, " latency"}, lat, el);
    chk({tag, " addr_valid"}, addr_valid, ev);
    if (ev) chk({tag, " addr"}, addr, ea);
    chk({tag, " wb_en"}, wb_en, ewb);
    if (ewb) begin
      chk({tag, " wb_data"}, wb_data, ewd);
      chk({tag, " R12 wb_idx"}, wb_idx, b);
    end
    @(negedge clk);
    mon_on = 1'b0;
    chk({tag, " mem requests"}, mreq_n, emr);
    if (emr > 0) chk({tag, " mem addr"}, mreq_a, ema);
    chk({tag, " R12 wb count"}, wb_n, ewb ? 1 : 0);
    chk({tag, " R11 done count"}, done_n, 1);
  endtask

  task automatic t_reset;
    chk("R1 done in reset", done, 0);
    chk("R1 mem_req in reset", mem_req, 0);
    repeat (2) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 done after reset", done, 0);
    chk("R1 mem_req after reset", mem_req, 0);
    chk("R1 wb_en after reset", wb_en, 0);
  endtask

  task automatic t_simple;
    run_op("R2 immediate", 0, 0, 2, 0, 16'h1234, 0, 0, 1, 0, 0, 0, 0);
    run_op("R2 register", 1, 0, 2, 0, 16'h1234, 0, 0, 1, 0, 0, 0, 0);
    run_op("R2 unused code 13", 13, 0, 2, 0, 16'h1234, 0, 0, 1, 0, 0, 0, 0);
    run_op("R3 direct", 2, 0, 2, 0, 16'h4321, 1, 16'h4321, 1, 0, 0, 0, 0);
    run_op("R3 reg indirect", 3, 0, 2, 0, 16'h0, 1, regs[2], 1, 0, 0, 0, 0);
  endtask

  task automatic t_auto;
    run_op("R4 R6 preinc size2", 4, 1, 4, 0, 0, 1, regs[4] + 16'd2, 1, 1, regs[4] + 16'd2, 0, 0);
    run_op("R5 R6 postinc size1", 5, 0, 4, 0, 0, 1, regs[4], 1, 1, regs[4] + 16'd1, 0, 0);
    run_op("R4 R6 predec wrap", 6, 2, 3, 0, 0, 1, 16'hFFFD, 1, 1, 16'hFFFD, 0, 0);
    run_op("R5 R6 postdec size code 3", 7, 3, 6, 0, 0, 1, regs[6], 1, 1, regs[6] - 16'd4, 0, 0);
  endtask

  task automatic t_offset;
    run_op("R7 R6 displacement wrap", 8, 0, 5, 0, 16'hFFF0, 1, 16'h0010, 1, 0, 0, 0, 0);
    run_op("R8 indexed", 9, 0, 2, 7, 0, 1, regs[2] + regs[7], 2, 0, 0, 0, 0);
  endtask

  task automatic t_indirect;
    logic [15:0] p;
    run_op("R9 memory indirect", 10, 0, 7, 0, 0, 1, memf(regs[7]), 3, 0, 0, 1, regs[7]);
    p = 16'h0024 + regs[5] + (regs[7] << 2);
    run_op("R10 scaled indirect", 11, 0, 5, 7, 16'h0024, 1, memf(p), 4, 0, 0, 1, p);
  endtask

  task automatic t_busy_start;
    int lat;
    logic [15:0] p;
    p = 16'h0100 + regs[2] + (regs[4] << 2);
    @(negedge clk);
    mode = 4'd11; size = 2'd0; base = 4'd2; idx = 4'd4; disp = 16'h0100; start = 1'b1;
    mreq_n = 0; done_n = 0; mon_on = 1'b1;
    @(negedge clk);
    mode = 4'd0; lat = 1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 12) begin @(negedge clk); lat++; end
    chk("R11 busy start latency", lat, 4);
    chk("R11 busy start addr", addr, memf(p));
    repeat (4) @(negedge clk);
    mon_on = 1'b0;
    chk("R11 busy start single done", done_n, 1);
    chk("R11 busy start single mem read", mreq_n, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 16'h1000 + 16'(i) * 16'h0111;
    regs[3] = 16'h0001;
    regs[5] = 16'h0020;
    regs[7] = 16'h0103;
    t_reset();
    t_simple();
    t_auto();
    t_offset();
    t_indirect();
    t_busy_start();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule